// File: doc/BRIEF.md
# Shared-Port Fetch Stall Controller

This controller arbitrates a single memory port shared by instruction fetch and data access in a five-stage pipeline. When the memory stage holds a load or a store, that access takes the port in the same cycle. The fetch that wanted the port loses the cycle. The controller then freezes the program counter and the fetch/decode register. It also sends an invalid slot (a bubble) into decode, so one later cycle retires nothing. Later instructions keep their spacing to each other and simply arrive one cycle later.

All arbitration outputs are combinational from the current memory-stage request flags. The only state is a stall-cycle counter, which a bench or debug logic can read.

Top module: `port_arb_stall`

## Requirements
- R1: `port_sel` is 1 (data side) in any cycle where `mem_rd` or `mem_wr` is high, and 0 (instruction side) otherwise, in the same cycle.
- R2: `data_grant` equals `mem_rd | mem_wr` in the same cycle; a data access is never refused.
- R3: `fetch_grant` is high only when `fetch_req` is high and neither `mem_rd` nor `mem_wr` is high; `data_grant` and `fetch_grant` are never high together.
- R4: When `fetch_req` is high and a data access is present, `pc_hold`, `ifid_hold` and `bubble` are all high in that cycle.
- R5: When no data access is present, `pc_hold`, `ifid_hold` and `bubble` are all low, whatever `fetch_req` is.
- R6: A store (`mem_wr`) causes exactly the same stall outputs as a load (`mem_rd`).
- R7: Back-to-back data accesses stall fetch on every cycle in which one is present, and fetch resumes in the first cycle with none.
- R8: `stall_count` (32 bits) is 0 after reset. It increases by one on each clock edge where a stall was asserted, and is otherwise unchanged; it wraps at 2^32.
- R9: A data access with `fetch_req` low asserts no stall and does not change `stall_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_rd | input | 1 | Memory stage holds a load |
| mem_wr | input | 1 | Memory stage holds a store |
| fetch_req | input | 1 | Fetch stage wants an instruction |
| data_grant | output | 1 | Port granted to the data access |
| fetch_grant | output | 1 | Port granted to the fetch |
| port_sel | output | 1 | Port address/data select: 1 data, 0 instruction |
| pc_hold | output | 1 | Freeze program counter |
| ifid_hold | output | 1 | Freeze fetch/decode register |
| bubble | output | 1 | Clear the fetch/decode valid bit (insert NOP) |
| stall_count | output | CNT_W | Stall cycles since reset |

## Verification
The grant, select, hold and bubble outputs are due in the same cycle as their inputs. The bench therefore drives inputs on the falling edge and samples these outputs before the next rising edge. `stall_count` is due one rising edge after a stall cycle. The bench keeps its own model count, which it updates at that edge, and compares it with `stall_count` on the following falling edge. An exhaustive sweep covers all eight input combinations, and runs of back-to-back accesses cover resumption and counting.

// File: rtl/port_arb_pkg.sv
package port_arb_pkg;
  typedef enum logic [0:0] {
    SEL_INSTR = 1'b0,
    SEL_DATA  = 1'b1
  } port_sel_e;

  function automatic logic data_wants(input logic rd, input logic wr);
    return rd | wr;
  endfunction

  function automatic logic conflict(input logic data, input logic fetch);
    return data & fetch;
  endfunction
endpackage

// File: rtl/port_arbiter.sv
module port_arbiter
  import port_arb_pkg::*;
(
  input  logic mem_rd,
  input  logic mem_wr,
  input  logic fetch_req,
  output logic data_grant,
  output logic fetch_grant,
  output logic port_sel,
  output logic clash
);
  logic data_req;
  port_sel_e sel_e;

  always_comb begin
    data_req    = data_wants(mem_rd, mem_wr);
    data_grant  = data_req;
    fetch_grant = fetch_req & ~data_req;
    clash       = conflict(data_req, fetch_req);
    sel_e       = data_req ? SEL_DATA : SEL_INSTR;
    port_sel    = sel_e;
  end

  always_comb begin
    assert_excl_grant_R3: assert (!(data_grant && fetch_grant));
    assert_sel_data_R1: assert (!(mem_rd || mem_wr) || port_sel);
  end
endmodule

// File: rtl/stall_ctl.sv
module stall_ctl (
  input  logic clash,
  output logic pc_hold,
  output logic ifid_hold,
  output logic bubble
);
  always_comb begin
    pc_hold   = clash;
    ifid_hold = clash;
    bubble    = clash;
  end
endmodule

// File: rtl/stall_counter.sv
module stall_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else if (inc) count <= count + ONE;
  end

  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> count == $past(count) + ONE);
  assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(count));
endmodule

// File: rtl/port_arb_stall.sv
module port_arb_stall #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mem_rd,
  input  logic             mem_wr,
  input  logic             fetch_req,
  output logic             data_grant,
  output logic             fetch_grant,
  output logic             port_sel,
  output logic             pc_hold,
  output logic             ifid_hold,
  output logic             bubble,
  output logic [CNT_W-1:0] stall_count
);
  logic clash;

  port_arbiter arb_i (
    .mem_rd(mem_rd), .mem_wr(mem_wr), .fetch_req(fetch_req),
    .data_grant(data_grant), .fetch_grant(fetch_grant),
    .port_sel(port_sel), .clash(clash)
  );

  stall_ctl ctl_i (
    .clash(clash), .pc_hold(pc_hold), .ifid_hold(ifid_hold), .bubble(bubble)
  );

  stall_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .inc(pc_hold), .count(stall_count)
  );

  always_comb begin
    assert_stall_on_clash_R4: assert (!(fetch_req && (mem_rd || mem_wr)) || (pc_hold && ifid_hold && bubble));
    assert_no_stall_idle_R5: assert ((mem_rd || mem_wr) || !(pc_hold || ifid_hold || bubble));
    assert_fetch_gated_R3: assert (!fetch_grant || (fetch_req && !mem_rd && !mem_wr));
  end
endmodule

// File: tb/port_arb_stall_tb_top.sv
module port_arb_stall_tb_top;
  logic clk = 0, rst_n = 0, mem_rd = 0, mem_wr = 0, fetch_req = 0;
  logic data_grant, fetch_grant, port_sel, pc_hold, ifid_hold, bubble;
  logic [31:0] stall_count;
  int total = 0, bad = 0;
  logic [31:0] model_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  port_arb_stall dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // apply inputs at negedge, check combinational outputs, then let posedge update count
  task automatic step(input logic rd, input logic wr, input logic fr);
    logic d, st;
    mem_rd = rd; mem_wr = wr; fetch_req = fr;
    #1;
    d  = rd | wr;
    st = d & fr;
    chk("R1 port_sel", {31'd0, port_sel}, {31'd0, d});
    chk("R2 data_grant", {31'd0, data_grant}, {31'd0, d});
    chk("R3 fetch_grant", {31'd0, fetch_grant}, {31'd0, fr & ~d});
    if (st) chk("R4 holds", {29'd0, pc_hold, ifid_hold, bubble}, 32'd7);
    else if (!d) chk("R5 no stall", {29'd0, pc_hold, ifid_hold, bubble}, 32'd0);
    else chk("R9 no stall without fetch", {29'd0, pc_hold, ifid_hold, bubble}, 32'd0);
    if (wr && !rd) chk("R6 store stalls like load", {31'd0, pc_hold}, {31'd0, fr});
    @(posedge clk);
    if (st) model_cnt = model_cnt + 1;
    @(negedge clk);
    chk("R8 stall_count", stall_count, model_cnt);
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    #1;
    chk("R8 reset count", stall_count, 32'd0);
    @(negedge clk);
    for (int r = 0; r < 3; r++)
      for (int v = 0; v < 8; v++) step(v[2], v[1], v[0]);
    // R7: back-to-back accesses with fetch pending
    for (int k = 0; k < 6; k++) begin
      step(k[0], ~k[0], 1'b1);
      chk("R7 stalled each access cycle", {31'd0, fetch_grant}, 32'd0);
    end
    step(1'b0, 1'b0, 1'b1);
    chk("R7 fetch resumes", {31'd0, fetch_grant}, 32'd1);
    // R9: accesses without fetch keep count
    for (int k = 0; k < 4; k++) step(1'b1, k[0], 1'b0);
    chk("R9 count unchanged", stall_count, model_cnt);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule